// File: doc/BRIEF.md
# Prioritised Pending-Interrupt Arbiter

This block holds one pending flag per interrupt source and, in any cycle where an evaluation strobe is raised, picks at most one source to hand to the exception-entry logic. Sources are ranked in a fixed order. Each source has its own eligibility rule, built from these inputs: the external-enable bit, a wake-as-reset flag, the hypervisor and problem-state bits, and a few partition control bits. Some sources can win even while external enable is clear.

The winner is reported as a one-cycle valid pulse with its code. On the same clock edge, the pending flag is dropped if that source clears on acknowledge. Level-style sources stay pending until their requester withdraws them. Requesters raise and drop flags through per-source set and clear strobes. A power-save entry strobe throws away a pending hypervisor decrementer. An evaluation made while waking as a reset that delivers nothing is reported on an error output.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted, all pending flags, `ack_valid` and `wake_err` are 0.
- R2: A `set_req[i]` pulse makes `pend_vec[i]` 1 after that clock edge. A `clr_req[i]` pulse makes it 0. When both arrive in the same cycle, the set wins.
- R3: On an evaluation edge, the lowest-index eligible source is delivered. `ack_code` is its index, with this encoding: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 hypervisor virtualization, 5 external, 6 critical external, 7 watchdog, 8 critical doorbell, 9 fixed-interval timer, 10 programmable timer, 11 decrementer, 12 doorbell, 13 hypervisor doorbell, 14 performance monitor, 15 thermal.
- R4: Sources 0, 1 and 2 are always eligible when pending. Each clears its pending flag when delivered.
- R5: Asynchronous delivery is allowed when `ext_en` or `wake_as_reset` is 1. Sources 7 to 15 are eligible only when asynchronous delivery is allowed.
- R6: Source 3 is eligible only when `hdec_en` is 1 and either asynchronous delivery is allowed or `hv` is 0. It clears when delivered.
- R7: Source 4 uses the same rule as source 3, with `hvirt_en` as its enable. It stays pending after delivery.
- R8: Source 5 is eligible in either of two cases. The first is when asynchronous delivery is allowed and the block condition (`hv_ext_block`=1, `hv`=1, `pr`=0) does not hold. The second is when hypervisor mode is present, `hv` is 0 and `part_ext_ctl` is 0. Source 5 stays pending after delivery.
- R9: Source 6 is always eligible when pending and stays pending after delivery.
- R10: Sources 7 to 15 clear when delivered, except source 11, which clears only when `dec_clr_on_ack` is 1.
- R11: A `pwr_save_enter` pulse clears the pending flag of source 3, even against a set strobe for source 3 in the same cycle.
- R12: An evaluation edge with `wake_as_reset`=1 and no eligible source sets `wake_err` for one cycle.
- R13: With `eval_en` low, `ack_valid` stays 0 and no pending flag is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 16 | Per-source set strobes |
| clr_req | input | 16 | Per-source clear strobes |
| eval_en | input | 1 | Evaluation strobe |
| ext_en | input | 1 | External-enable bit |
| wake_as_reset | input | 1 | Waking from power save as a reset |
| hv | input | 1 | Hypervisor state bit |
| pr | input | 1 | Problem state bit |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| hvirt_en | input | 1 | Hypervisor virtualization enable |
| hv_ext_block | input | 1 | Blocks external delivery to the hypervisor |
| part_ext_ctl | input | 1 | Partition external control bit |
| dec_clr_on_ack | input | 1 | Decrementer clears on delivery |
| pwr_save_enter | input | 1 | Power-save entry strobe |
| ack_valid | output | 1 | One-cycle delivery pulse |
| ack_code | output | CODE_W | Delivered source code |
| wake_err | output | 1 | Wake evaluation delivered nothing |
| pend_vec | output | 16 | Pending flags |

## Verification
Every result is registered once. A strobe or evaluation applied before clock edge k shows up in `pend_vec`, `ack_valid`, `ack_code` and `wake_err` just after edge k, with no later effect. For each stimulus cycle, the driver computes the outcome from its own model of the requirements and pushes it into a queue. One nanosecond after each rising edge, the monitor pops one entry per edge and compares it with all four outputs. This keeps expectation and observation aligned to exactly one edge of latency.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int unsigned SRC_N = 16;

   localparam int unsigned IDX_RESET  = 0;
   localparam int unsigned IDX_MCHK   = 1;
   localparam int unsigned IDX_DEBUG  = 2;
   localparam int unsigned IDX_HDEC   = 3;
   localparam int unsigned IDX_HVIRT  = 4;
   localparam int unsigned IDX_EXT    = 5;
   localparam int unsigned IDX_CEXT   = 6;
   localparam int unsigned IDX_ASYNC0 = 7;
   localparam int unsigned IDX_DEC    = 11;

   typedef struct packed {
      logic ee;
      logic wake;
      logic hv;
      logic pr;
      logic hdec_en;
      logic hvirt_en;
      logic hext_block;
      logic part_ext;
   } gate_ctl_t;

   // Sources that always drop their flag on delivery (decrementer excluded)
   function automatic logic [SRC_N-1:0] self_clear_mask();
      logic [SRC_N-1:0] m;
      m = '0;
      m[IDX_RESET] = 1'b1;
      m[IDX_MCHK]  = 1'b1;
      m[IDX_DEBUG] = 1'b1;
      m[IDX_HDEC]  = 1'b1;
      for (int i = IDX_ASYNC0; i < SRC_N; i++) m[i] = (i != IDX_DEC);
      return m;
   endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
   import irq_arb_pkg::*;
#(
   parameter int unsigned N          = SRC_N,
   parameter bit          HV_PRESENT = 1'b1
) (
   input  gate_ctl_t        ctl,
   input  logic [N-1:0]     pend,
   output logic [N-1:0]     elig
);
   localparam int unsigned ASYNC_W = N - IDX_ASYNC0;

   logic async_ok;
   logic hv_side_ext;
   logic ext_blocked;

   assign async_ok    = ctl.ee | ctl.wake;
   assign ext_blocked = ctl.hext_block & ctl.hv & ~ctl.pr;

   generate
      if (HV_PRESENT) begin : g_hv
         assign hv_side_ext = ~ctl.hv & ~ctl.part_ext;
      end else begin : g_nohv
         assign hv_side_ext = 1'b0;
      end
   endgenerate

   always_comb begin
      elig = '0;
      elig[IDX_RESET] = pend[IDX_RESET];
      elig[IDX_MCHK]  = pend[IDX_MCHK];
      elig[IDX_DEBUG] = pend[IDX_DEBUG];
      elig[IDX_HDEC]  = pend[IDX_HDEC]  & ctl.hdec_en  & (async_ok | ~ctl.hv);
      elig[IDX_HVIRT] = pend[IDX_HVIRT] & ctl.hvirt_en & (async_ok | ~ctl.hv);
      elig[IDX_EXT]   = pend[IDX_EXT] & ((async_ok & ~ext_blocked) | hv_side_ext);
      elig[IDX_CEXT]  = pend[IDX_CEXT];
      elig[N-1:IDX_ASYNC0] = pend[N-1:IDX_ASYNC0] & {ASYNC_W{async_ok}};
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N      = 16,
   parameter int unsigned CODE_W = 4
) (
   input  logic [N-1:0]      req,
   output logic [N-1:0]      grant,
   output logic              hit,
   output logic [CODE_W-1:0] code
);
   generate
      if (CODE_W < $clog2(N)) begin : g_bad_w
         $error("CODE_W too narrow for source count");
      end
   endgenerate

   always_comb begin
      grant = '0;
      code  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            code  = CODE_W'(i);
         end
      end
   end

   assign hit = |req;
endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] consume_i,
   input  logic [N-1:0] discard_i,
   output logic [N-1:0] pend_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)             pend_o[i] <= 1'b0;
            else if (discard_i[i])  pend_o[i] <= 1'b0;
            else if (set_i[i])      pend_o[i] <= 1'b1;
            else if (clr_i[i] | consume_i[i]) pend_o[i] <= 1'b0;
         end

         // R2: a set strobe that is not discarded lands
         a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] && !discard_i[i]) |=> pend_o[i]);
      end
   endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned CODE_W     = 4,
   parameter bit          HV_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       set_req,
   input  logic [15:0]       clr_req,
   input  logic              eval_en,
   input  logic              ext_en,
   input  logic              wake_as_reset,
   input  logic              hv,
   input  logic              pr,
   input  logic              hdec_en,
   input  logic              hvirt_en,
   input  logic              hv_ext_block,
   input  logic              part_ext_ctl,
   input  logic              dec_clr_on_ack,
   input  logic              pwr_save_enter,
   output logic              ack_valid,
   output logic [CODE_W-1:0] ack_code,
   output logic              wake_err,
   output logic [15:0]       pend_vec
);
   localparam int unsigned N = SRC_N;
   localparam logic [N-1:0] CLR_BASE = self_clear_mask();
   localparam logic [N-1:0] DEC_BIT  = N'(1) << IDX_DEC;
   localparam logic [N-1:0] HDEC_BIT = N'(1) << IDX_HDEC;

   gate_ctl_t         ctl;
   logic [N-1:0]      pend_q, elig, grant, clr_policy, consume, discard;
   logic              hit;
   logic [CODE_W-1:0] code;

   assign ctl = '{ee: ext_en, wake: wake_as_reset, hv: hv, pr: pr,
                  hdec_en: hdec_en, hvirt_en: hvirt_en,
                  hext_block: hv_ext_block, part_ext: part_ext_ctl};

   irq_gate #(.N(N), .HV_PRESENT(HV_PRESENT)) u_gate (
      .ctl  (ctl),
      .pend (pend_q),
      .elig (elig)
   );

   irq_prio_pick #(.N(N), .CODE_W(CODE_W)) u_pick (
      .req   (elig),
      .grant (grant),
      .hit   (hit),
      .code  (code)
   );

   assign clr_policy = CLR_BASE | (dec_clr_on_ack ? DEC_BIT : '0);
   assign consume    = eval_en ? (grant & clr_policy) : '0;
   assign discard    = pwr_save_enter ? HDEC_BIT : '0;

   irq_pend_store #(.N(N)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_req),
      .clr_i     (clr_req),
      .consume_i (consume),
      .discard_i (discard),
      .pend_o    (pend_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_code  <= '0;
         wake_err  <= 1'b0;
      end else begin
         ack_valid <= eval_en & hit;
         ack_code  <= (eval_en & hit) ? code : '0;
         wake_err  <= eval_en & wake_as_reset & ~hit;
      end
   end

   assign pend_vec = pend_q;

   // R13: no delivery without an evaluation strobe
   a_r13_no_eval_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eval_en) |-> !ack_valid);

   // R12: the error flag never accompanies a delivery
   a_r12_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      wake_err |-> !ack_valid);

   // R4: a delivered reset leaves its flag clear unless re-set on that edge
   a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_code == CODE_W'(IDX_RESET) && !$past(set_req[IDX_RESET]))
      |-> !pend_vec[IDX_RESET]);

   // R7: hypervisor virtualization stays pending after delivery
   a_r7_hvirt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_code == CODE_W'(IDX_HVIRT) && !$past(clr_req[IDX_HVIRT]))
      |-> pend_vec[IDX_HVIRT]);

   // R11: power-save entry discards the hypervisor decrementer
   a_r11_pwrsave_discard: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_save_enter) |-> !pend_vec[IDX_HDEC]);
endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] set_req, clr_req;
   logic        eval_en, ext_en, wake_as_reset, hv, pr, hdec_en, hvirt_en;
   logic        hv_ext_block, part_ext_ctl, dec_clr_on_ack, pwr_save_enter;
   logic        ack_valid, wake_err;
   logic [3:0]  ack_code;
   logic [15:0] pend_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [15:0] m_pend;
   bit          q_v[$];
   int          q_c[$];
   bit          q_w[$];
   logic [15:0] q_p[$];
   string       q_t[$];

   always #2 clk = ~clk;

   irq_arbiter dut (
      .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
      .eval_en(eval_en), .ext_en(ext_en), .wake_as_reset(wake_as_reset),
      .hv(hv), .pr(pr), .hdec_en(hdec_en), .hvirt_en(hvirt_en),
      .hv_ext_block(hv_ext_block), .part_ext_ctl(part_ext_ctl),
      .dec_clr_on_ack(dec_clr_on_ack), .pwr_save_enter(pwr_save_enter),
      .ack_valid(ack_valid), .ack_code(ack_code), .wake_err(wake_err),
      .pend_vec(pend_vec)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Eligibility per the requirements (R4..R10)
   function automatic logic [15:0] elig_of(logic [15:0] p);
      logic [15:0] e;
      logic a;
      a = ext_en | wake_as_reset;
      e = '0;
      e[2:0] = p[2:0];
      e[3]   = p[3] & hdec_en  & (a | ~hv);
      e[4]   = p[4] & hvirt_en & (a | ~hv);
      e[5]   = p[5] & ((a & ~(hv_ext_block & hv & ~pr)) | (~hv & ~part_ext_ctl));
      e[6]   = p[6];
      e[15:7] = p[15:7] & {9{a}};
      return e;
   endfunction

   // Driver: one clock edge with the current inputs, expectation queued
   task automatic cyc(string tag);
      logic [15:0] e, cons;
      int win;
      win = -1;
      e = elig_of(m_pend);
      for (int i = 15; i >= 0; i--) if (e[i]) win = i;
      cons = '0;
      if (eval_en && win >= 0) begin
         if (win != 4 && win != 5 && win != 6 && !(win == 11 && !dec_clr_on_ack))
            cons[win] = 1'b1;
      end
      q_v.push_back(eval_en && win >= 0);
      q_c.push_back((eval_en && win >= 0) ? win : 0);
      q_w.push_back(eval_en && wake_as_reset && win < 0);
      m_pend = ((m_pend & ~cons) & ~clr_req) | set_req;
      if (pwr_save_enter) m_pend[3] = 1'b0;
      q_p.push_back(m_pend);
      q_t.push_back(tag);
      @(negedge clk);
      set_req = '0; clr_req = '0; eval_en = 0; pwr_save_enter = 0;
   endtask

   // Monitor: compares one queued item per rising edge
   always @(posedge clk) begin
      #1;
      if (q_t.size() > 0) begin
         string t;
         t = q_t.pop_front();
         chk(t, "ack_valid", int'(ack_valid), int'(q_v.pop_front()));
         chk(t, "ack_code",  int'(ack_code),  q_c.pop_front());
         chk(t, "wake_err",  int'(wake_err),  int'(q_w.pop_front()));
         chk(t, "pend_vec",  int'(pend_vec),  int'(q_p.pop_front()));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst_n = 0; set_req = '0; clr_req = '0; eval_en = 0; ext_en = 0;
      wake_as_reset = 0; hv = 0; pr = 0; hdec_en = 0; hvirt_en = 0;
      hv_ext_block = 0; part_ext_ctl = 0; dec_clr_on_ack = 0; pwr_save_enter = 0;
      m_pend = '0;
      set_req = 16'hFFFF;
      repeat (3) @(negedge clk);
      chk("R1", "pend_vec", int'(pend_vec), 0);
      chk("R1", "ack_valid", int'(ack_valid), 0);
      chk("R1", "wake_err", int'(wake_err), 0);
      set_req = '0;
      rst_n = 1;
      @(negedge clk);

      // R2: set, then set+clear collision, then clear
      set_req = 16'h0001; cyc("R2");
      set_req = 16'h0002; clr_req = 16'h0002; cyc("R2");
      clr_req = 16'h0003; cyc("R2");

      // R4: unconditional trio delivered in order with enable clear
      set_req = 16'h0007; cyc("R4");
      eval_en = 1; cyc("R4");
      eval_en = 1; cyc("R4");
      eval_en = 1; cyc("R4");
      eval_en = 1; cyc("R13"); // nothing left

      // R6: hypervisor decrementer gating
      set_req = 16'h0008; hv = 1; cyc("R6");
      eval_en = 1; cyc("R6");           // enable off
      hdec_en = 1; eval_en = 1; cyc("R6"); // hv=1, no async
      hv = 0; eval_en = 1; cyc("R6");   // delivered and cleared

      // R7: hypervisor virtualization stays pending
      set_req = 16'h0010; hv = 1; hvirt_en = 1; ext_en = 1; cyc("R7");
      eval_en = 1; cyc("R7");
      eval_en = 1; cyc("R7");
      clr_req = 16'h0010; cyc("R7");

      // R8: external gating
      set_req = 16'h0020; hv_ext_block = 1; hv = 1; pr = 0; part_ext_ctl = 1; cyc("R8");
      eval_en = 1; cyc("R8");           // blocked
      pr = 1; eval_en = 1; cyc("R8");   // delivered, stays
      ext_en = 0; hv = 0; pr = 0; part_ext_ctl = 0; eval_en = 1; cyc("R8");
      part_ext_ctl = 1; eval_en = 1; cyc("R8"); // no path
      clr_req = 16'h0020; hv_ext_block = 0; cyc("R8");

      // R9: critical external ignores enable, stays pending
      set_req = 16'h0040; cyc("R9");
      eval_en = 1; cyc("R9");
      clr_req = 16'h0040; cyc("R9");

      // R5/R10: asynchronous group
      set_req = 16'hFF80; cyc("R5");
      eval_en = 1; cyc("R5");           // enable clear: held
      ext_en = 1;
      for (int k = 0; k < 5; k++) begin eval_en = 1; cyc("R10"); end
      eval_en = 1; cyc("R10");          // decrementer again
      dec_clr_on_ack = 1; eval_en = 1; cyc("R10");
      ext_en = 0; wake_as_reset = 1;
      for (int k = 0; k < 4; k++) begin eval_en = 1; cyc("R5"); end

      // R12: wake evaluation with nothing deliverable
      eval_en = 1; cyc("R12");
      wake_as_reset = 0;

      // R3: priority among mixed sources
      ext_en = 1; hv = 0; hdec_en = 1; part_ext_ctl = 0;
      set_req = 16'h0868; cyc("R3");
      for (int k = 0; k < 4; k++) begin eval_en = 1; cyc("R3"); end
      clr_req = 16'hFFFF; cyc("R3");

      // R13: pending but not evaluated
      set_req = 16'h0001; cyc("R13");
      cyc("R13");
      clr_req = 16'h0001; cyc("R13");

      // R11: power-save discards decrementer, also against a same-cycle set
      set_req = 16'h0008; cyc("R11");
      pwr_save_enter = 1; cyc("R11");
      set_req = 16'h0008; pwr_save_enter = 1; cyc("R11");

      @(posedge clk); #2;
      finish_run();
   end
endmodule